// File: doc/BRIEF.md
# Residue Gain Compensation Path

This block runs once per reference strobe in a fractional-N synthesizer. A fractional phase accumulator adds the frequency control word, with its lowest bit forced high, on every strobe. The overflow of that sum is the carry that dithers a dual-modulus divider. The remaining sum is the residue. The residue feeds a digital path that drives a charge-based cancellation DAC.

The DAC delivers its charge as two amplitude steps instead of as a shift in time. This causes a gain error that depends on frequency and grows roughly with the square of the residue. To correct it, the upper residue bits address a small table of shape-correction values, which is built when the design is elaborated. The table value is first-differenced against the value from the previous strobe. A fixed factor, chosen for the nominal divide ratio, scales the difference. The scaled difference is then added to the residue.

A first-order noise-shaping quantizer reduces the corrected word to the DAC control code. A compensation enable can remove the correction term, so that the plain residue is quantized.

Top module: `gcp_residue_comp`

## Requirements
- R1: On each cycle with `ref_stb_i` high, the 20-bit residue becomes (residue + (`fcw_i` with bit 0 forced to 1)) mod 2^20. The residue does not change in other cycles.
- R2: `carry_o` is the overflow (bit 20) of the R1 addition, registered on the strobe and held unchanged until the next strobe.
- R3: The table is addressed by residue bits [19:14] (address a, 0..63). It returns floor(a*(63-a)/64), a 4-bit value. In general: X address bits, Y-bit entries, shift 2X-Y-2.
- R4: With `comp_en_i` high, the word sent to the quantizer is residue + 3*(T_now - T_prev)*2^8. T_now is the table value of the residue held before the strobe. T_prev is the table value used at the previous strobe.
- R5: With `comp_en_i` low, the correction term is zero and the quantizer receives the residue unchanged. The history value still advances on every strobe.
- R6: On each strobe the quantizer forms s = word + e, where e is the stored error. The code is floor(s/2^13) saturated to 0..127, and the stored error becomes s mod 2^13. `dac_code_o` changes only in the cycle after a strobe.
- R7: Asynchronous active-low reset clears the residue, `carry_o`, `dac_code_o`, the quantizer error and the table history. The first strobe after reset therefore uses a previous table value of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| ref_stb_i | input | 1 | reference-rate update strobe |
| comp_en_i | input | 1 | enables the differentiated shape correction |
| fcw_i | input | 20 | fractional frequency control word |
| carry_o | output | 1 | divider dither carry |
| dac_code_o | output | 7 | noise-shaped DAC control code |

## Verification
The checker enforces four rules on every clock:
- the accumulator step and its carry match the previous residue and control word (R1, R2);
- both outputs hold still between strobes;
- the correction term leaving the differentiator is zero whenever compensation is off.

The table contents, the differencing against the previous strobe, the scale and alignment of the correction, the carried quantizer error and the saturation at the code limits show only as numeric code values. Only the bench's per-cycle reference model can confirm them. The bench covers slow and fast residue motion, a near-full control word, irregular strobes, enable toggling and a reset mid-run.

// File: rtl/gcp_pkg.sv
package gcp_pkg;
  // Quadratic shape-correction entry, peak scaled to just under 2^dw (R3)
  function automatic int unsigned shape_entry(int unsigned a, int unsigned aw, int unsigned dw);
    int unsigned amax;
    amax = (32'd1 << aw) - 1;
    return (a * (amax - a)) >> (2 * aw - dw - 2);
  endfunction

  function automatic int unsigned max_u(int unsigned x, int unsigned y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/gcp_phase_acc.sv
module gcp_phase_acc #(
  parameter int unsigned ACC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic [ACC_W-1:0] fcw_i,
  output logic [ACC_W-1:0] residue_o,
  output logic             carry_o
);
  logic [ACC_W:0] sum;

  // LSB forced high to randomize the residue (R1)
  assign sum = {1'b0, residue_o} + {1'b0, (fcw_i | ACC_W'(1))};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      residue_o <= '0;
      carry_o   <= 1'b0;
    end else if (stb_i) begin
      residue_o <= sum[ACC_W-1:0];
      carry_o   <= sum[ACC_W];
    end
  end
endmodule

// File: rtl/gcp_shape_lut.sv
module gcp_shape_lut #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 4
) (
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] tbl [DEPTH];

  // contents fixed at elaboration (R3)
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam int unsigned VAL = gcp_pkg::shape_entry(i, AW, DW);
    assign tbl[i] = DW'(VAL);
  end

  assign data_o = tbl[addr_i];
endmodule

// File: rtl/gcp_diff_corr.sv
module gcp_diff_corr #(
  parameter int unsigned DW      = 4,
  parameter int unsigned SCALE   = 3,
  parameter int unsigned CORR_SH = 8,
  localparam int unsigned SC_W   = $clog2(SCALE + 1) + 1,
  localparam int unsigned CORR_W = DW + 1 + SC_W + CORR_SH
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     stb_i,
  input  logic                     en_i,
  input  logic [DW-1:0]            lut_i,
  output logic signed [CORR_W-1:0] corr_o
);
  logic [DW-1:0]            prev_q;
  logic signed [DW:0]       delta;
  logic signed [CORR_W-1:0] scaled;

  // history advances every strobe, cleared on reset (R5, R7)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prev_q <= '0;
    else if (stb_i) prev_q <= lut_i;
  end

  assign delta  = signed'({1'b0, lut_i}) - signed'({1'b0, prev_q});
  assign scaled = (CORR_W'(delta) * signed'(CORR_W'(SCALE))) <<< CORR_SH;
  assign corr_o = en_i ? scaled : '0;  // R4, R5
endmodule

// File: rtl/gcp_nsq.sv
module gcp_nsq #(
  parameter int unsigned IN_W  = 23,
  parameter int unsigned DAC_W = 7,
  parameter int unsigned Q     = 13
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   stb_i,
  input  logic signed [IN_W-1:0] word_i,
  output logic [DAC_W-1:0]       code_o
);
  localparam logic signed [IN_W-1:0] CODE_MAX = IN_W'((1 << DAC_W) - 1);

  logic [Q-1:0]           err_q;
  logic signed [IN_W-1:0] s;
  logic signed [IN_W-1:0] quo;
  logic [DAC_W-1:0]       code_d;

  assign s   = word_i + signed'({{(IN_W-Q){1'b0}}, err_q});
  assign quo = s >>> Q;

  always_comb begin
    if (quo < 0)             code_d = '0;
    else if (quo > CODE_MAX) code_d = CODE_MAX[DAC_W-1:0];
    else                     code_d = quo[DAC_W-1:0];
  end

  // first-order error feedback (R6)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= '0;
      code_o <= '0;
    end else if (stb_i) begin
      err_q  <= s[Q-1:0];
      code_o <= code_d;
    end
  end
endmodule

// File: rtl/gcp_residue_comp.sv
module gcp_residue_comp #(
  parameter int unsigned ACC_W   = 20,
  parameter int unsigned LUT_AW  = 6,
  parameter int unsigned LUT_DW  = 4,
  parameter int unsigned DAC_W   = 7,
  parameter int unsigned SCALE   = 3,
  parameter int unsigned CORR_SH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_stb_i,
  input  logic             comp_en_i,
  input  logic [ACC_W-1:0] fcw_i,
  output logic             carry_o,
  output logic [DAC_W-1:0] dac_code_o
);
  localparam int unsigned SC_W   = $clog2(SCALE + 1) + 1;
  localparam int unsigned CORR_W = LUT_DW + 1 + SC_W + CORR_SH;
  localparam int unsigned SUM_W  = gcp_pkg::max_u(ACC_W, CORR_W) + 3;
  localparam int unsigned Q      = ACC_W - DAC_W;

  logic [ACC_W-1:0]         residue;
  logic [LUT_DW-1:0]        lut_val;
  logic signed [CORR_W-1:0] corr_w;
  logic signed [SUM_W-1:0]  comp_word;

  gcp_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (ref_stb_i),
    .fcw_i     (fcw_i),
    .residue_o (residue),
    .carry_o   (carry_o)
  );

  gcp_shape_lut #(.AW(LUT_AW), .DW(LUT_DW)) u_lut (
    .addr_i (residue[ACC_W-1 -: LUT_AW]),
    .data_o (lut_val)
  );

  gcp_diff_corr #(.DW(LUT_DW), .SCALE(SCALE), .CORR_SH(CORR_SH)) u_diff (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (ref_stb_i),
    .en_i   (comp_en_i),
    .lut_i  (lut_val),
    .corr_o (corr_w)
  );

  assign comp_word = signed'(SUM_W'(residue)) + SUM_W'(corr_w);

  gcp_nsq #(.IN_W(SUM_W), .DAC_W(DAC_W), .Q(Q)) u_nsq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (ref_stb_i),
    .word_i (comp_word),
    .code_o (dac_code_o)
  );
endmodule

// File: rtl/gcp_residue_comp_chk.sv
module gcp_residue_comp_chk #(
  parameter int unsigned ACC_W  = 20,
  parameter int unsigned DAC_W  = 7,
  parameter int unsigned CORR_W = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     ref_stb_i,
  input logic                     comp_en_i,
  input logic [ACC_W-1:0]         fcw_i,
  input logic [ACC_W-1:0]         residue,
  input logic                     carry_o,
  input logic [DAC_W-1:0]         dac_code_o,
  input logic signed [CORR_W-1:0] corr_w
);
  AST_ACC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ref_stb_i) |-> ({carry_o, residue} ==
      ({1'b0, $past(residue)} + {1'b0, ($past(fcw_i) | ACC_W'(1))}))); // R1

  AST_CARRY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ref_stb_i) |-> ($stable(carry_o) && $stable(residue))); // R2

  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ref_stb_i) |-> $stable(dac_code_o)); // R6

  AST_CORR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !comp_en_i |-> (corr_w == '0)); // R5
endmodule

bind gcp_residue_comp gcp_residue_comp_chk #(
  .ACC_W(ACC_W), .DAC_W(DAC_W), .CORR_W(CORR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ref_stb_i  (ref_stb_i),
  .comp_en_i  (comp_en_i),
  .fcw_i      (fcw_i),
  .residue    (residue),
  .carry_o    (carry_o),
  .dac_code_o (dac_code_o),
  .corr_w     (corr_w)
);

// File: tb/tb_gcp_residue_comp.sv
module tb_gcp_residue_comp;
  localparam int ACC_W = 20;
  localparam int DAC_W = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             stb = 1'b0;
  logic             en = 1'b0;
  logic [ACC_W-1:0] fcw = '0;
  logic             carry;
  logic [DAC_W-1:0] code;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gcp_residue_comp dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_stb_i(stb), .comp_en_i(en),
    .fcw_i(fcw), .carry_o(carry), .dac_code_o(code)
  );

  // reference model state
  longint m_acc, m_prev, m_err;
  int     m_code;
  bit     m_carry;
  int unsigned lcg = 32'h1234_5678;

  // quadratic table: peak of a*(63-a) is 992, divided by 64 (R3)
  function automatic longint tbl(longint a);
    return (a * (63 - a)) / 64;
  endfunction

  function automatic int unsigned next_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_prev = 0; m_err = 0; m_code = 0; m_carry = 0;
    end else if (stb) begin
      longint t, corr, s, q, nxt;
      t    = tbl(m_acc >> 14);
      corr = en ? (t - m_prev) * 3 * 256 : 0;        // R4 R5
      s    = m_acc + corr + m_err;
      q    = s >>> 13;
      m_code = (q < 0) ? 0 : ((q > 127) ? 127 : int'(q)); // R6
      m_err  = s & 8191;
      m_prev = t;
      nxt    = m_acc + longint'(fcw | 20'd1);         // R1
      m_carry = nxt[20];                              // R2
      m_acc   = nxt & 20'hFFFFF;
    end
  end

  task automatic compare(string tag);
    vectors++;
    if (carry !== m_carry) begin
      miscompares++;
      $display("FAIL %s carry: got %0d exp %0d at %0t", tag, carry, m_carry, $time);
    end
    if (int'(code) !== m_code) begin
      miscompares++;
      $display("FAIL %s code: got %0d exp %0d at %0t", tag, code, m_code, $time);
    end
  endtask

  // mode 0: every cycle, 1: every third, 2: pseudo-random; fmode 1: random fcw
  task automatic run(int n, logic [ACC_W-1:0] f, bit fmode, bit e, bit toggle_en, int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare(en ? "R1 R2 R3 R4 R6" : "R1 R2 R5 R6");
      fcw <= fmode ? ACC_W'(next_rand() >> 7) : f;
      en  <= toggle_en ? next_rand()[20] : e;
      case (mode)
        0:       stb <= 1'b1;
        1:       stb <= (i % 3 == 0);
        default: stb <= next_rand()[15];
      endcase
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R7 reset");
    if (code !== '0 || carry !== 1'b0) begin
      miscompares++;
      $display("FAIL R7 outputs not zero in reset: code %0d carry %0d exp 0 0", code, carry);
    end
    vectors++;
    rst_n = 1'b1;

    run(400,  20'h00100, 0, 1, 0, 0);   // slow residue, table steps rare
    run(400,  20'h80000, 0, 1, 0, 0);   // forced LSB keeps residue moving
    run(400,  20'hFFFFE, 0, 1, 0, 0);   // carry on nearly every strobe, saturation region
    run(300,  20'h00000, 0, 0, 0, 0);   // R5 correction off, step of one
    run(600,  20'h12345, 0, 0, 0, 1);   // R5 sparse strobes
    run(600,  20'h2AAAA, 0, 1, 0, 1);   // R4 sparse strobes
    run(3000, 20'h00000, 1, 1, 1, 2);   // random word, enable and strobes

    // asynchronous reset mid-run (R7)
    @(negedge clk);
    compare("R6");
    rst_n = 1'b0;
    stb <= 1'b0;
    #1;
    vectors++;
    if (code !== '0 || carry !== 1'b0) begin
      miscompares++;
      $display("FAIL R7 async reset: code %0d carry %0d exp 0 0", code, carry);
    end
    repeat (2) @(negedge clk);
    compare("R7 held");
    rst_n = 1'b1;
    run(500, 20'h0F0F1, 0, 1, 0, 0);    // R7 history restarts from zero
    run(200, 20'h00000, 1, 1, 1, 0);
    @(negedge clk);
    compare("R6 final");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule